// File: doc/BRIEF.md
# Bus-to-Slow-Clock Shadow Register Bridge

The bridge carries register writes from a fast bus clock into shadow registers that live in a slow real-time clock domain (nominally 32768 Hz). Every bus write lands at once in a bus-side view and a holding register, and it raises a per-register pending flag. The value then crosses into the slow domain through a toggle request/acknowledge handshake, with a chain of synchronizer flops in each direction. Software reads the pending flags and treats a write as complete only when they have all returned to zero. This makes the pending flags a write fence.

A single interrupt status bit lives in the slow domain. A slow-side event sets it, and it drives the interrupt line directly. A write-1 clear from the bus clears the bus view at once, but the interrupt line drops only after the clear has crossed on a slow-clock edge. Slow-domain state reaches the bus view only through a reload command. The reload takes a snapshot in the slow domain and copies it back. A control bit enables the forward transfers. While it is clear, writes are held and the newest value waits.

The bus port is a flat word-indexed register file. Word indices 0 to NUM_REGS-1 are the shadow data registers, NUM_REGS is control, NUM_REGS+1 is interrupt status, and NUM_REGS+2 is sync status.

Top module: `shadow_sync_bridge`

## Requirements
- R1: After reset, every bus view and every slow shadow equals RESET_VAL (zero by default), all pending flags read 0, the control and status words read 0, and `slow_irq_o` is low.
- R2: A bus write to a data index is returned by a bus read of that index from the next bus cycle on, before any transfer completes.
- R3: A write to data index i sets bit i of the sync status word at the next bus clock edge. Bit NUM_REGS of that word is the pending flag of an interrupt clear.
- R4: When control bit 0 (sync enable) is 1, a write to an idle register starts its transfer on the following bus edge. Its pending flag returns to 0 within 3 slow-clock periods plus 6 bus cycles of the write, and the slow shadow then holds the value.
- R5: Each completed transfer changes only the targeted slow shadow, and only to the value carried by that transfer.
- R6: While sync enable is 0, writes and interrupt clears do not cross. Their pending flags stay at 1 and the slow shadows keep their old values.
- R7: Writes to a register whose flag is already pending overwrite the holding data. An in-flight value still completes, and after it only the newest held value crosses. Intermediate values are dropped.
- R8: A pulse on `slow_event_i` sets the slow interrupt status and raises `slow_irq_o` at the next slow edge. The bus-side status view does not change until a reload.
- R9: Writing 1 to bit DATA_W-1 of the sync status word starts a reload, and that bit reads 1 until the reload completes. The reload then copies the slow interrupt status and the slow shadows of non-pending registers into the bus views. Reload does not depend on sync enable.
- R10: Writing 1 to bit 0 of the interrupt status word clears its bus view at the next bus edge. `slow_irq_o` stays high until the clear crosses on a slow edge, and the clear uses pending bit NUM_REGS. Writing 0 there has no effect.
- R11: A reload leaves unchanged the bus view of any register whose pending flag is set when the reload completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Fast bus clock |
| clk_slow | input | 1 | Slow real-time domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_we_i | input | 1 | Bus write strobe, one write per asserted cycle |
| bus_addr_i | input | ADDR_W | Word index of the access |
| bus_wdata_i | input | DATA_W | Bus write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i`, combinational |
| slow_event_i | input | 1 | Slow-domain event that sets interrupt status |
| slow_regs_o | output | NUM_REGS*DATA_W | Slow shadow registers, index 0 in the low bits |
| slow_irq_o | output | 1 | Interrupt line driven from slow-domain status |

## Verification
The bench targets four cases. Back-to-back writes while a transfer is in flight must deliver exactly the first and the last value; a design that relaunched from live holding data would show an intermediate or torn value in the slow shadow. Writes held while sync is disabled must leave the shadows untouched, and a reload issued then must not overwrite the newer pending bus view with stale slow data. An interrupt clear is sampled in the window where the bus view already reads clear but the line must still be high. A design that dropped the line early, or that never dropped it, is caught there. The fence latency is bounded, so a handshake that never acknowledges or that takes extra slow cycles shows up as a count over the limit.

// File: rtl/shadow_sync_pkg.sv
package shadow_sync_pkg;

   // Kinds of word index on the bus side of the bridge.
   typedef enum logic [1:0] {
      SPACE_DATA,
      SPACE_CTRL,
      SPACE_INT,
      SPACE_SYNC
   } space_e;

   // Number of address bits needed to index n words (at least one).
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Classify a word index given the number of data registers.
   function automatic space_e classify(input int unsigned idx, input int unsigned n_regs);
      if (idx < n_regs)          return SPACE_DATA;
      else if (idx == n_regs)    return SPACE_CTRL;
      else if (idx == n_regs + 1) return SPACE_INT;
      else                       return SPACE_SYNC;
   endfunction

endpackage

// File: rtl/ssb_sync_cell.sv
module ssb_sync_cell #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ssb_sync_cell: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ssb_write_channel.sv
module ssb_write_channel #(
   parameter int                DATA_W      = 32,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] RESET_VAL   = '0
) (
   input  logic              clk_bus,
   input  logic              clk_slow,
   input  logic              rst_n,
   // bus domain
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              launch_en_i,
   output logic              pending_o,
   // slow domain
   output logic              rx_stb_o,
   output logic [DATA_W-1:0] rx_data_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("ssb_write_channel: DATA_W must be positive");
   end

   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] xfer_q;
   logic              dirty_q;
   logic              req_q;
   logic              ack_sync;
   logic              busy;
   logic              launch;
   logic              req_sync;
   logic              req_seen_q;

   // A request is outstanding while the returned toggle lags the sent one.
   assign busy   = req_q ^ ack_sync;
   assign launch = dirty_q & launch_en_i & ~busy;

   always_ff @(posedge clk_bus or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= RESET_VAL;
         xfer_q  <= RESET_VAL;
         dirty_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         if (wr_en_i) hold_q <= wr_data_i;
         if (launch) begin
            xfer_q <= hold_q;
            req_q  <= ~req_q;
         end
         dirty_q <= wr_en_i | (dirty_q & ~launch);
      end
   end

   assign pending_o = dirty_q | busy;

   // request toggle into the slow domain
   ssb_sync_cell #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (clk_slow),
      .rst_n (rst_n),
      .d_i   (req_q),
      .q_o   (req_sync)
   );

   always_ff @(posedge clk_slow or negedge rst_n) begin
      if (!rst_n) req_seen_q <= 1'b0;
      else        req_seen_q <= req_sync;
   end

   assign rx_stb_o  = req_sync ^ req_seen_q;
   assign rx_data_o = xfer_q;

   // acknowledge toggle back into the bus domain
   ssb_sync_cell #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk_bus),
      .rst_n (rst_n),
      .d_i   (req_seen_q),
      .q_o   (ack_sync)
   );

   // R3: a write raises the pending flag on the next bus edge
   a_r3_write_sets_pending : assert property (
      @(posedge clk_bus) disable iff (!rst_n) wr_en_i |=> pending_o);

   // R6: no new request toggle while transfers are disabled
   a_r6_no_launch_disabled : assert property (
      @(posedge clk_bus) disable iff (!rst_n) !launch_en_i |=> $stable(req_q));

   // R7: the crossing payload is frozen while its request is outstanding
   a_r7_payload_frozen : assert property (
      @(posedge clk_bus) disable iff (!rst_n) busy |=> $stable(xfer_q));

endmodule

// File: rtl/ssb_reload_link.sv
module ssb_reload_link #(
   parameter int SNAP_W      = 65,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_bus,
   input  logic              clk_slow,
   input  logic              rst_n,
   // bus domain
   input  logic              start_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [SNAP_W-1:0] snap_o,
   // slow domain
   input  logic [SNAP_W-1:0] state_i
);

   if (SNAP_W < 1) begin : g_bad_snap
      $error("ssb_reload_link: SNAP_W must be positive");
   end

   logic              req_q;
   logic              ack_sync;
   logic              ack_seen_q;
   logic              req_sync;
   logic              seen_q;
   logic [SNAP_W-1:0] snap_q;

   assign busy_o = req_q ^ ack_seen_q;
   assign done_o = ack_sync ^ ack_seen_q;

   always_ff @(posedge clk_bus or negedge rst_n) begin
      if (!rst_n) begin
         req_q      <= 1'b0;
         ack_seen_q <= 1'b0;
      end else begin
         if (start_i && !busy_o) req_q <= ~req_q;
         ack_seen_q <= ack_sync;
      end
   end

   ssb_sync_cell #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (clk_slow),
      .rst_n (rst_n),
      .d_i   (req_q),
      .q_o   (req_sync)
   );

   // the snapshot is taken on the slow edge that acknowledges
   always_ff @(posedge clk_slow or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         snap_q <= '0;
      end else begin
         seen_q <= req_sync;
         if (req_sync ^ seen_q) snap_q <= state_i;
      end
   end

   ssb_sync_cell #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (clk_bus),
      .rst_n (rst_n),
      .d_i   (seen_q),
      .q_o   (ack_sync)
   );

   assign snap_o = snap_q;

   // R9: an accepted reload shows as busy from the next bus cycle
   a_r9_reload_busy : assert property (
      @(posedge clk_bus) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o);

   // R9: completion only happens for an outstanding reload
   a_r9_done_needs_busy : assert property (
      @(posedge clk_bus) disable iff (!rst_n) done_o |-> busy_o);

endmodule

// File: rtl/shadow_sync_bridge.sv
module shadow_sync_bridge
   import shadow_sync_pkg::*;
#(
   parameter int                NUM_REGS    = 2,
   parameter int                DATA_W      = 32,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] RESET_VAL   = '0,
   localparam int               ADDR_W      = idx_bits(NUM_REGS + 3)
) (
   input  logic                       clk_bus,
   input  logic                       clk_slow,
   input  logic                       rst_n,
   input  logic                       bus_we_i,
   input  logic [ADDR_W-1:0]          bus_addr_i,
   input  logic [DATA_W-1:0]          bus_wdata_i,
   output logic [DATA_W-1:0]          bus_rdata_o,
   input  logic                       slow_event_i,
   output logic [NUM_REGS*DATA_W-1:0] slow_regs_o,
   output logic                       slow_irq_o
);

   localparam int PEND_W     = NUM_REGS + 1;
   localparam int IRQ_CH     = NUM_REGS;
   localparam int RELOAD_BIT = DATA_W - 1;
   localparam int SNAP_W     = NUM_REGS * DATA_W + 1;

   if (NUM_REGS < 1) begin : g_bad_regs
      $error("shadow_sync_bridge: NUM_REGS must be at least 1");
   end
   if (DATA_W < PEND_W + 1) begin : g_bad_width
      $error("shadow_sync_bridge: DATA_W too narrow for pending and reload bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("shadow_sync_bridge: SYNC_STAGES must be at least 2");
   end

   // ---------------------------------------------------------------- decode
   space_e            acc_space;
   logic              ctrl_wr;
   logic              irq_clr_wr;
   logic              reload_start;
   logic [NUM_REGS-1:0] reg_wr;

   assign acc_space    = classify(int'(bus_addr_i), NUM_REGS);
   assign ctrl_wr      = bus_we_i && (acc_space == SPACE_CTRL);
   assign irq_clr_wr   = bus_we_i && (acc_space == SPACE_INT) && bus_wdata_i[0];
   assign reload_start = bus_we_i && (acc_space == SPACE_SYNC)
                         && (int'(bus_addr_i) == NUM_REGS + 2) && bus_wdata_i[RELOAD_BIT];

   // ---------------------------------------------------------------- control
   logic sync_en_q;

   always_ff @(posedge clk_bus or negedge rst_n) begin
      if (!rst_n)       sync_en_q <= 1'b0;
      else if (ctrl_wr) sync_en_q <= bus_wdata_i[0];
   end

   // ---------------------------------------------------------------- channels
   logic [PEND_W-1:0]   pend;
   logic [NUM_REGS-1:0] data_stb;
   logic [DATA_W-1:0]   data_rx   [NUM_REGS];
   logic [DATA_W-1:0]   shadow_q  [NUM_REGS];
   logic [DATA_W-1:0]   view_q    [NUM_REGS];
   logic                irq_stb;
   logic [0:0]          irq_rx;
   logic                slow_irq_q;
   logic                view_irq_q;
   logic                reload_busy;
   logic                reload_done;
   logic [SNAP_W-1:0]   snap;
   logic [SNAP_W-1:0]   slow_state;

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      assign reg_wr[gi] = bus_we_i && (int'(bus_addr_i) == gi);

      ssb_write_channel #(
         .DATA_W      (DATA_W),
         .SYNC_STAGES (SYNC_STAGES),
         .RESET_VAL   (RESET_VAL)
      ) u_chan (
         .clk_bus     (clk_bus),
         .clk_slow    (clk_slow),
         .rst_n       (rst_n),
         .wr_en_i     (reg_wr[gi]),
         .wr_data_i   (bus_wdata_i),
         .launch_en_i (sync_en_q),
         .pending_o   (pend[gi]),
         .rx_stb_o    (data_stb[gi]),
         .rx_data_o   (data_rx[gi])
      );

      // slow-side shadow register
      always_ff @(posedge clk_slow or negedge rst_n) begin
         if (!rst_n)            shadow_q[gi] <= RESET_VAL;
         else if (data_stb[gi]) shadow_q[gi] <= data_rx[gi];
      end

      assign slow_regs_o[gi*DATA_W +: DATA_W] = shadow_q[gi];
      assign slow_state[gi*DATA_W +: DATA_W]  = shadow_q[gi];

      // bus-side view: a write wins over a reload; pending views are kept
      always_ff @(posedge clk_bus or negedge rst_n) begin
         if (!rst_n)
            view_q[gi] <= RESET_VAL;
         else if (reg_wr[gi])
            view_q[gi] <= bus_wdata_i;
         else if (reload_done && !pend[gi])
            view_q[gi] <= snap[gi*DATA_W +: DATA_W];
      end

      // R2: a data write is visible in the bus view on the next cycle
      a_r2_view_takes_write : assert property (
         @(posedge clk_bus) disable iff (!rst_n)
         reg_wr[gi] |=> (view_q[gi] == $past(bus_wdata_i)));

      // R5: a slow shadow moves only on a delivered transfer
      a_r5_shadow_on_delivery : assert property (
         @(posedge clk_slow) disable iff (!rst_n)
         !data_stb[gi] |=> $stable(shadow_q[gi]));

      // R11: a reload does not touch a pending register view
      a_r11_pending_view_kept : assert property (
         @(posedge clk_bus) disable iff (!rst_n)
         (reload_done && pend[gi] && !reg_wr[gi]) |=> $stable(view_q[gi]));
   end

   // interrupt-clear channel, payload-free apart from a marker bit
   ssb_write_channel #(
      .DATA_W      (1),
      .SYNC_STAGES (SYNC_STAGES),
      .RESET_VAL   (1'b0)
   ) u_irq_chan (
      .clk_bus     (clk_bus),
      .clk_slow    (clk_slow),
      .rst_n       (rst_n),
      .wr_en_i     (irq_clr_wr),
      .wr_data_i   (1'b1),
      .launch_en_i (sync_en_q),
      .pending_o   (pend[IRQ_CH]),
      .rx_stb_o    (irq_stb),
      .rx_data_o   (irq_rx)
   );

   // slow interrupt status: a new event wins over a simultaneous clear
   always_ff @(posedge clk_slow or negedge rst_n) begin
      if (!rst_n)                    slow_irq_q <= 1'b0;
      else if (slow_event_i)         slow_irq_q <= 1'b1;
      else if (irq_stb && irq_rx[0]) slow_irq_q <= 1'b0;
   end

   assign slow_irq_o            = slow_irq_q;
   assign slow_state[SNAP_W-1]  = slow_irq_q;

   // ---------------------------------------------------------------- reload
   ssb_reload_link #(
      .SNAP_W      (SNAP_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_reload (
      .clk_bus  (clk_bus),
      .clk_slow (clk_slow),
      .rst_n    (rst_n),
      .start_i  (reload_start),
      .busy_o   (reload_busy),
      .done_o   (reload_done),
      .snap_o   (snap),
      .state_i  (slow_state)
   );

   always_ff @(posedge clk_bus or negedge rst_n) begin
      if (!rst_n)
         view_irq_q <= 1'b0;
      else if (irq_clr_wr)
         view_irq_q <= 1'b0;
      else if (reload_done && !pend[IRQ_CH])
         view_irq_q <= snap[SNAP_W-1];
   end

   // ---------------------------------------------------------------- read mux
   always_comb begin
      bus_rdata_o = '0;
      unique case (acc_space)
         SPACE_DATA: begin
            for (int i = 0; i < NUM_REGS; i++)
               if (int'(bus_addr_i) == i) bus_rdata_o = view_q[i];
         end
         SPACE_CTRL: bus_rdata_o[0] = sync_en_q;
         SPACE_INT:  bus_rdata_o[0] = view_irq_q;
         SPACE_SYNC: begin
            if (int'(bus_addr_i) == NUM_REGS + 2) begin
               bus_rdata_o[PEND_W-1:0] = pend;
               bus_rdata_o[RELOAD_BIT] = reload_busy;
            end
         end
         default: bus_rdata_o = '0;
      endcase
   end

   // R10: a clear write empties the bus-side status view at once
   a_r10_view_clear : assert property (
      @(posedge clk_bus) disable iff (!rst_n) irq_clr_wr |=> !view_irq_q);

   // R8: a slow event raises the interrupt line at the next slow edge
   a_r8_event_raises_irq : assert property (
      @(posedge clk_slow) disable iff (!rst_n) slow_event_i |=> slow_irq_o);

endmodule

// File: tb/test_shadow_sync_bridge.sv
module test_shadow_sync_bridge;

   localparam int NUM_REGS = 2;
   localparam int DATA_W   = 32;
   localparam int ADDR_W   = 3;
   localparam int A_CTRL   = 2;
   localparam int A_INT    = 3;
   localparam int A_SYNC   = 4;
   localparam int SLOW_CYC = 14;                 // bus cycles per slow period, rounded up
   localparam int FENCE_MAX = 3 * SLOW_CYC + 6;  // R4 bound

   logic                       clk_bus = 1'b0;
   logic                       clk_slow = 1'b0;
   logic                       rst_n = 1'b0;
   logic                       bus_we = 1'b0;
   logic [ADDR_W-1:0]          bus_addr = '0;
   logic [DATA_W-1:0]          bus_wdata = '0;
   logic [DATA_W-1:0]          bus_rdata;
   logic                       slow_event = 1'b0;
   logic [NUM_REGS*DATA_W-1:0] slow_regs;
   logic                       slow_irq;

   always #10  clk_bus  = ~clk_bus;    // 50 MHz
   always #131 clk_slow = ~clk_slow;   // slow domain, never edge-aligned with bus

   shadow_sync_bridge #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_shadow_sync_bridge (
      .clk_bus      (clk_bus),
      .clk_slow     (clk_slow),
      .rst_n        (rst_n),
      .bus_we_i     (bus_we),
      .bus_addr_i   (bus_addr),
      .bus_wdata_i  (bus_wdata),
      .bus_rdata_o  (bus_rdata),
      .slow_event_i (slow_event),
      .slow_regs_o  (slow_regs),
      .slow_irq_o   (slow_irq)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // scoreboard of expected slow-shadow updates: {index, value}
   logic [35:0] exp_q[$];
   logic [NUM_REGS*DATA_W-1:0] last_slow = '0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic bus_write(input int addr, input logic [31:0] data);
      @(negedge clk_bus);
      bus_we    = 1'b1;
      bus_addr  = ADDR_W'(addr);
      bus_wdata = data;
      @(negedge clk_bus);
      bus_we    = 1'b0;
   endtask

   task automatic bus_read(input int addr, output logic [31:0] data);
      bus_addr = ADDR_W'(addr);
      #1;
      data = bus_rdata;
   endtask

   task automatic fence(output int cycles);
      logic [31:0] v;
      cycles = 0;
      bus_read(A_SYNC, v);
      while (v[NUM_REGS:0] != '0 && cycles < 400) begin
         @(negedge clk_bus);
         cycles++;
         bus_read(A_SYNC, v);
      end
   endtask

   task automatic wait_reload();
      logic [31:0] v;
      int n = 0;
      bus_read(A_SYNC, v);
      while (v[31] && n < 400) begin
         @(negedge clk_bus);
         n++;
         bus_read(A_SYNC, v);
      end
      check(!v[31], "R9 reload completes", v, 32'h0);
   endtask

   task automatic expect_slow(input int idx, input logic [31:0] val);
      exp_q.push_back({4'(idx), val});
   endtask

   // monitor: compares every slow-shadow change against the scoreboard
   always @(negedge clk_slow) begin
      if (rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) begin
            if (slow_regs[i*DATA_W +: DATA_W] != last_slow[i*DATA_W +: DATA_W]) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R5 unexpected slow update", slow_regs[i*DATA_W +: DATA_W], 32'h0);
               end else begin
                  logic [35:0] e;
                  e = exp_q.pop_front();
                  check(int'(e[35:32]) == i && slow_regs[i*DATA_W +: DATA_W] == e[31:0],
                        "R5 R7 slow update order", slow_regs[i*DATA_W +: DATA_W], e[31:0]);
               end
            end
         end
         last_slow = slow_regs;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk_bus);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int cyc;

      repeat (5) @(negedge clk_bus);
      rst_n = 1'b1;
      @(negedge clk_bus);

      // ---------------- R1 reset state
      for (int a = 0; a < 5; a++) begin
         bus_read(a, v);
         check(v == 32'h0, "R1 reset read", v, 32'h0);
      end
      check(slow_regs == '0, "R1 slow shadows", slow_regs[31:0], 32'h0);
      check(!slow_irq, "R1 irq low", {31'h0, slow_irq}, 32'h0);

      // enable sync
      bus_write(A_CTRL, 32'h1);

      // ---------------- R2 R3 R4 R5 basic write
      expect_slow(0, 32'h1234_5678);
      bus_write(0, 32'h1234_5678);
      bus_read(0, v);
      check(v == 32'h1234_5678, "R2 view after write", v, 32'h1234_5678);
      bus_read(A_SYNC, v);
      check(v[0] == 1'b1, "R3 pending bit 0", v, 32'h1);
      fence(cyc);
      check(cyc + 1 <= FENCE_MAX, "R4 fence latency", cyc + 1, FENCE_MAX);
      check(slow_regs[31:0] == 32'h1234_5678, "R4 slow reg0 after fence", slow_regs[31:0], 32'h1234_5678);
      check(slow_regs[63:32] == 32'h0, "R5 reg1 untouched", slow_regs[63:32], 32'h0);

      expect_slow(1, 32'hCAFE_0001);
      bus_write(1, 32'hCAFE_0001);
      bus_read(A_SYNC, v);
      check(v[1] == 1'b1 && v[0] == 1'b0, "R3 pending bit 1", v, 32'h2);
      fence(cyc);
      check(cyc + 1 <= FENCE_MAX, "R4 fence latency reg1", cyc + 1, FENCE_MAX);

      // ---------------- R6 disabled transfers, R11 reload keeps pending view
      bus_write(A_CTRL, 32'h0);
      @(negedge clk_bus);
      bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 32'hAAAA_0001;
      @(negedge clk_bus);
      bus_wdata = 32'hAAAA_0002;
      @(negedge clk_bus);
      bus_wdata = 32'hAAAA_0003;
      @(negedge clk_bus);
      bus_we = 1'b0;
      repeat (10) @(negedge clk_slow);
      @(negedge clk_bus);
      bus_read(A_SYNC, v);
      check(v[1] == 1'b1, "R6 pending held while disabled", v, 32'h2);
      check(slow_regs[63:32] == 32'hCAFE_0001, "R6 slow reg1 unchanged", slow_regs[63:32], 32'hCAFE_0001);

      bus_write(A_SYNC, 32'h8000_0000);
      bus_read(A_SYNC, v);
      check(v[31] == 1'b1, "R9 reload bit busy", v, 32'h8000_0002);
      wait_reload();
      bus_read(1, v);
      check(v == 32'hAAAA_0003, "R11 pending view kept on reload", v, 32'hAAAA_0003);
      bus_read(0, v);
      check(v == 32'h1234_5678, "R9 non-pending view refreshed", v, 32'h1234_5678);

      // ---------------- R7 only newest held value crosses
      expect_slow(1, 32'hAAAA_0003);
      bus_write(A_CTRL, 32'h1);
      fence(cyc);
      check(slow_regs[63:32] == 32'hAAAA_0003, "R7 newest value delivered", slow_regs[63:32], 32'hAAAA_0003);

      // ---------------- R7 burst during an in-flight transfer
      expect_slow(0, 32'hD000_000D);
      expect_slow(0, 32'hF000_000F);
      @(negedge clk_bus);
      bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'hD000_000D;
      @(negedge clk_bus);
      bus_wdata = 32'hE000_000E;
      @(negedge clk_bus);
      bus_wdata = 32'hF000_000F;
      @(negedge clk_bus);
      bus_we = 1'b0;
      fence(cyc);
      check(slow_regs[31:0] == 32'hF000_000F, "R7 burst final value", slow_regs[31:0], 32'hF000_000F);

      // ---------------- R8 slow event, bus view waits for reload
      @(negedge clk_slow);
      slow_event = 1'b1;
      @(negedge clk_slow);
      slow_event = 1'b0;
      repeat (2) @(negedge clk_slow);
      @(negedge clk_bus);
      check(slow_irq, "R8 irq raised", {31'h0, slow_irq}, 32'h1);
      bus_read(A_INT, v);
      check(v == 32'h0, "R8 bus view not yet updated", v, 32'h0);

      bus_write(A_SYNC, 32'h8000_0000);
      wait_reload();
      bus_read(A_INT, v);
      check(v == 32'h1, "R9 reload brings status", v, 32'h1);

      // ---------------- R10 interrupt clear
      bus_write(A_INT, 32'h0);
      bus_read(A_INT, v);
      check(v == 32'h1, "R10 write 0 no effect", v, 32'h1);
      bus_read(A_SYNC, v);
      check(v[2] == 1'b0, "R10 write 0 no pending", v, 32'h0);

      bus_write(A_INT, 32'h1);
      bus_read(A_INT, v);
      check(v == 32'h0, "R10 view cleared at once", v, 32'h0);
      check(slow_irq, "R10 line still high", {31'h0, slow_irq}, 32'h1);
      bus_read(A_SYNC, v);
      check(v[2] == 1'b1, "R10 clear pending bit", v, 32'h4);
      fence(cyc);
      check(!slow_irq, "R10 line dropped after crossing", {31'h0, slow_irq}, 32'h0);

      repeat (4) @(negedge clk_slow);
      @(negedge clk_bus);
      check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 32'h0);
      finish_run();
   end

endmodule